// File: doc/BRIEF.md
# Sample-Jump Error Corrector

This block sits behind a narrowband lowpass filter whose arithmetic may, now and then, produce a badly wrong output. Such errors mostly land in the high-order bits. A genuine narrowband signal changes only a little from one sample to the next. A corrupted sample therefore shows up as a large jump away from the last trusted value. The block measures that jump for every valid input sample and compares its magnitude with a threshold supplied from outside. When the jump is too large, the block replaces the sample with the last trusted value and raises a flag.

Only accepted samples become the new reference. A burst of bad samples is therefore always judged against the last good one, and never against an earlier replacement. The first sample after reset has nothing to compare with, so it is taken as it arrives. The corrected sample, its flag and a saturating count of rejected samples appear one clock after the input.

Top module: `diff_err_corrector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, out_err, out_data and err_count are all zero.
- R2: out_valid is high exactly one cycle after a cycle with in_valid high, and low otherwise.
- R3: The first valid sample after reset is passed to out_data whatever the threshold is, with out_err low, and it becomes the reference.
- R4: The jump is the signed difference (in_data minus reference), formed one bit wider than the data. Its magnitude is exact over the whole range, including a swing from the most negative to the most positive code.
- R5: A sample is rejected only when the jump magnitude is strictly greater than the unsigned value of thresh. A magnitude equal to thresh is accepted.
- R6: For a rejected sample, out_data equals the current reference, which is the last accepted sample, and out_err is 1.
- R7: For an accepted sample, out_data equals in_data, out_err is 0, and in_data becomes the new reference.
- R8: A rejected sample does not change the reference. Consecutive rejected samples are all compared with, and replaced by, the same last accepted value.
- R9: err_count rises by one in the same cycle that out_err is high, and it holds at its all-ones value instead of wrapping.
- R10: thresh is used in the cycle in which in_valid is high, so a new value applies from the very next sample.
- R11: In cycles with in_valid low, the reference, out_data and err_count keep their values, and out_err is 0 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Filter output sample present |
| in_data | input | DATA_W | Filter output sample, two's complement |
| thresh | input | DATA_W+1 | Largest allowed jump magnitude, unsigned |
| out_valid | output | 1 | Corrected sample present |
| out_data | output | DATA_W | Corrected sample, two's complement |
| out_err | output | 1 | The sample was rejected and replaced |
| err_count | output | CNT_W | Saturating count of rejected samples |

## Verification
The assertions check the following on every cycle: the one-cycle timing of the valid and flag outputs, that a rejected sample repeats the previous output, that an accepted sample passes straight through, that the first sample is never flagged, the counter's step-and-hold behaviour, and that nothing moves on idle cycles. The assertions cannot see whether the threshold decision itself is right. The bench therefore covers that point: the exact magnitude at the extremes of the range, the strict comparison at equality, and a reference that stays fixed through runs of rejected samples. It does this by sweeping every pair of reference and input at every threshold across the full range of the differences, on a 4-bit configuration.

// File: rtl/dec_pkg.sv
package dec_pkg;
  typedef enum logic {
    REF_EMPTY  = 1'b0,
    REF_LOADED = 1'b1
  } ref_state_e;
endpackage

// File: rtl/dec_jump_mag.sv
module dec_jump_mag #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] ref_i,
  output logic [DATA_W:0]   mag_o
);
  localparam int WIDE_W = DATA_W + 1;

  function automatic logic [WIDE_W-1:0] wide_diff(
    input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    logic [WIDE_W-1:0] ax, bx;
    ax = {a[DATA_W-1], a};
    bx = {b[DATA_W-1], b};
    return ax - bx;
  endfunction

  // Two's complement magnitude read as unsigned. The most negative wide code
  // maps onto 2**DATA_W, which still fits the unsigned field exactly.
  function automatic logic [WIDE_W-1:0] magnitude(input logic [WIDE_W-1:0] d);
    return d[WIDE_W-1] ? (~d + 1'b1) : d;
  endfunction

  logic [WIDE_W-1:0] diff;
  assign diff  = wide_diff(cur_i, ref_i);
  assign mag_o = magnitude(diff);
endmodule

// File: rtl/dec_limit_cmp.sv
module dec_limit_cmp #(
  parameter int MAG_W = 9
) (
  input  logic [MAG_W-1:0] mag_i,
  input  logic [MAG_W-1:0] limit_i,
  output logic             over_o
);
  function automatic logic exceeds(input logic [MAG_W-1:0] m, input logic [MAG_W-1:0] l);
    return m > l;
  endfunction

  assign over_o = exceeds(mag_i, limit_i);
endmodule

// File: rtl/dec_sat_counter.sv
module dec_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                          count_o <= '0;
    else if (inc_i && count_o != CNT_MAX) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/diff_err_corrector.sv
module diff_err_corrector #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W:0]   thresh,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err,
  output logic [CNT_W-1:0]  err_count
);
  import dec_pkg::*;
  localparam int MAG_W = DATA_W + 1;

  ref_state_e        ref_state;
  logic [DATA_W-1:0] ref_q;
  logic [MAG_W-1:0]  jump_mag;
  logic              jump_over;

  // Named events for the checker
  logic first_sample;
  logic jump_err;
  logic accept;

  dec_jump_mag #(.DATA_W(DATA_W)) mag_i (
    .cur_i (in_data),
    .ref_i (ref_q),
    .mag_o (jump_mag)
  );

  dec_limit_cmp #(.MAG_W(MAG_W)) cmp_i (
    .mag_i   (jump_mag),
    .limit_i (thresh),
    .over_o  (jump_over)
  );

  assign first_sample = in_valid && (ref_state == REF_EMPTY);
  assign jump_err     = in_valid && (ref_state == REF_LOADED) && jump_over;
  assign accept       = in_valid && !jump_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_state <= REF_EMPTY;
      ref_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_err   <= jump_err;
      if (in_valid) out_data <= jump_err ? ref_q : in_data;
      if (accept) begin
        ref_q     <= in_data;
        ref_state <= REF_LOADED;
      end
    end
  end

  dec_sat_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (jump_err),
    .count_o (err_count)
  );
endmodule

// File: rtl/dec_corrector_chk.sv
module dec_corrector_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_err,
  input logic [CNT_W-1:0]  err_count,
  input logic              first_sample,
  input logic              jump_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DATA_W-1:0] last_out;
  logic              seen_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_out <= '0;
      seen_out <= 1'b0;
    end else if (out_valid) begin
      last_out <= out_data;
      seen_out <= 1'b1;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_err)); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R11
  AST_FIRST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    first_sample |=> !out_err); // R3
  AST_REPEAT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (seen_out && out_data == last_out)); // R6
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !jump_err) |=> (out_data == $past(in_data))); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_err && $past(err_count) != CNT_MAX) |-> (err_count == $past(err_count) + 1'b1)); // R9
  AST_COUNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !out_err |-> $stable(err_count)); // R9
endmodule

bind diff_err_corrector dec_corrector_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_data      (in_data),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_err      (out_err),
  .err_count    (err_count),
  .first_sample (first_sample),
  .jump_err     (jump_err)
);

// File: tb/diff_err_corrector_tb_top.sv
module diff_err_corrector_tb_top;
  localparam int W      = 4;
  localparam int CW     = 4;
  localparam int TW     = W + 1;
  localparam int TMAX   = (1 << TW) - 1;
  localparam int CMAX   = (1 << CW) - 1;
  localparam int DMIN   = -(1 << (W - 1));
  localparam int DMAX   = (1 << (W - 1)) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic [TW-1:0] thresh = '0;
  logic          out_valid;
  logic [W-1:0]  out_data;
  logic          out_err;
  logic [CW-1:0] err_count;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;
  int  m_ref   = 0;
  bit  m_primed = 0;
  int  m_cnt   = 0;
  int  m_out   = 0;

  always #10 clk = ~clk;

  diff_err_corrector #(.DATA_W(W), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .thresh(thresh), .out_valid(out_valid), .out_data(out_data),
    .out_err(out_err), .err_count(err_count)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    m_ref = 0; m_primed = 0; m_cnt = 0; m_out = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
    check(out_err == 1'b0, "R1", "out_err", int'(out_err), 0);
    check(out_data == '0, "R1", "out_data", int'(out_data), 0);
    check(err_count == '0, "R1", "err_count", int'(err_count), 0);
  endtask

  // Called at a negative edge; returns at the negative edge after the result.
  task automatic send(input int x, input int t, input string req);
    int d; int m; bit e;
    e = 1'b0;
    if (m_primed) begin
      d = x - m_ref;
      m = (d < 0) ? -d : d;
      e = (m > t);
    end
    m_out = e ? m_ref : x;
    if (!e) begin m_ref = x; m_primed = 1'b1; end
    if (e && m_cnt < CMAX) m_cnt++;
    in_valid = 1'b1; in_data = x[W-1:0]; thresh = t[TW-1:0];
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R2", "out_valid", int'(out_valid), 1);
    check($signed(out_data) == m_out, req, "out_data", int'($signed(out_data)), m_out);
    check(out_err == e, req, "out_err", int'(out_err), int'(e));
    check(int'(err_count) == m_cnt, "R9", "err_count", int'(err_count), m_cnt);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_data = in_data + 1'b1; thresh = '0;
      @(posedge clk); @(negedge clk);
      check(out_valid == 1'b0, "R2", "idle out_valid", int'(out_valid), 0);
      check(out_err == 1'b0, "R11", "idle out_err", int'(out_err), 0);
      check($signed(out_data) == m_out, "R11", "idle out_data", int'($signed(out_data)), m_out);
      check(int'(err_count) == m_cnt, "R11", "idle err_count", int'(err_count), m_cnt);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    // R3: first sample taken even with zero threshold
    send(DMAX, 0, "R3");
    // R6/R8: burst of bad samples judged against the same reference
    send(DMIN, 0, "R6");
    send(DMIN, 0, "R8");
    send(DMIN + 1, 0, "R8");
    // R5: equality accepted, one above rejected
    send(DMAX, 0, "R5");
    send(DMAX - 4, 4, "R5");
    send(DMAX, 3, "R5");
    // R4: full-range swings
    send(DMAX, TMAX, "R7");
    send(DMIN, 2 * DMAX, "R4");
    send(DMIN, 2 * DMAX + 1, "R4");
    send(DMAX, 2 * DMAX, "R4");
    // R10: threshold changes between back-to-back samples
    send(DMIN + 3, 3, "R10");
    send(DMIN + 6, 2, "R10");
    send(DMIN + 6, 3, "R10");
    // R11: idle cycles leave state untouched
    idle(3);
    send(DMIN + 7, 1, "R11");
    send(DMIN + 9, 1, "R11");
    // R3 again after a fresh reset
    do_reset();
    send(DMIN, 0, "R3");
    send(DMAX, 0, "R6");
    // Exhaustive sweep: every reference, input and threshold; saturates R9
    for (int r = DMIN; r <= DMAX; r++)
      for (int x = DMIN; x <= DMAX; x++)
        for (int t = 0; t <= 2 * DMAX + 2; t++) begin
          send(r, TMAX, "R7");
          send(x, t, "R5");
        end
    idle(2);
    summary();
  end
endmodule